// File: doc/BRIEF.md
# Floating-Point Rounding and Accuracy Mode Resolver

This block sits between instruction decode and the arithmetic datapath of a scalar floating-point unit. For each issued instruction it picks the rounding mode to use, either the static mode carried in the instruction or the dynamic mode held in the floating-point control word. It also resolves an accuracy mode from a field in that control word, and passes on the operand format taken from the instruction. The accuracy mode ranges from the fastest approximation up to a correctly rounded result.

Not every accuracy mode has to exist in hardware. A parameter mask lists the modes that are built. When software asks for a mode that is missing, a more accurate mode that is built may serve it instead, if that substitution is enabled. Otherwise the block requests an emulation trap, so that a handler can produce the result in software.

Faults show up as one-cycle pulses in the same cycle as the issue strobe. An invalid rounding mode raises an illegal-instruction pulse, and an unserved accuracy mode raises a trap pulse. A faulting instruction forwards nothing to the datapath. The control word can be written and read back. It also exposes a read-only bit that tells user code whether its current accuracy mode would be emulated.

Top module: `fp_round_acc_resolver`

## Requirements
- R1: After reset the control word reads all zeros, and `out_valid`, `illegal_insn`, `emu_trap` and all `eff_*` outputs are zero.
- R2: The control word packs sticky flags in bits [4:0], the dynamic rounding mode in [7:5] and the accuracy mode in [9:8]. A write with `csr_we` high is visible on `csr_rdata` from the next cycle. An instruction issued in the same cycle as the write still uses the old value. Bit 10 ignores writes.
- R3: An instruction rounding field of 000 to 100 is forwarded unchanged on `eff_rm`, whatever the dynamic field holds.
- R4: An instruction rounding field of 111 forwards the dynamic rounding mode from bits [7:5].
- R5: An instruction is illegal in either of two cases: its rounding field is 101 or 110, or it is 111 while the dynamic mode is 101, 110 or 111. In that case `illegal_insn` pulses in the issue cycle.
- R6: The two-bit format field (00 = 32-bit, 01 = 64-bit, 10 = 16-bit, 11 = 128-bit) is forwarded unchanged on `eff_fmt` for an accepted instruction.
- R7: The accuracy encoding is 00 fastest, 01 a few ULP, 10 under 1 ULP, 11 correctly rounded. A requested mode whose `IMPL_MASK` bit is set is forwarded unchanged.
- R8: Suppose the requested mode is not implemented, `ALLOW_UPGRADE` is set, and some more accurate mode is implemented. Then the least accurate of those more accurate implemented modes is forwarded, and no trap is raised.
- R9: If the requested mode cannot be served, `emu_trap` pulses in the issue cycle and `out_valid` stays low.
- R10: An illegal rounding mode takes priority over an emulation trap. On any fault `out_valid` is low and every `eff_*` output is zero.
- R11: With `issue_valid` low, no output pulses, whatever the instruction fields hold.
- R12: Control-word bit 10 reads 1 exactly when the current accuracy mode would cause an emulation trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction issue strobe |
| insn_rm | input | 3 | Instruction rounding-mode field |
| insn_fmt | input | 2 | Instruction operand-format field |
| csr_we | input | 1 | Control-word write enable |
| csr_wdata | input | FLAG_W+5 | Control-word write data |
| csr_rdata | output | FLAG_W+6 | Control-word read data with emulation status bit on top |
| out_valid | output | 1 | Accepted instruction, effective modes valid |
| eff_rm | output | 3 | Effective rounding mode |
| eff_acc | output | 2 | Effective accuracy mode |
| eff_fmt | output | 2 | Effective operand format |
| illegal_insn | output | 1 | Illegal-instruction pulse |
| emu_trap | output | 1 | Emulation trap request pulse |

## Verification
The held state is the control word, so a wrong internal value shows up in the cycle after the write in two places: the readback on `csr_rdata`, and the emulation status bit. The next instruction that uses dynamic rounding then shows the wrong `eff_rm`, or a missing or spurious `illegal_insn`. A wrong accuracy field or a faulty substitution search shows up in that same issue cycle, as a wrong `eff_acc` or a wrong `emu_trap`. The bench therefore writes a control word before each issue and checks every output in the issue cycle itself.

// File: rtl/fp_round_acc_resolver.sv
module fp_round_acc_resolver #(
  parameter logic [3:0] IMPL_MASK     = 4'b0101,
  parameter bit         ALLOW_UPGRADE = 1'b1,
  parameter int         FLAG_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [2:0]        insn_rm,
  input  logic [1:0]        insn_fmt,
  input  logic              csr_we,
  input  logic [FLAG_W+4:0] csr_wdata,
  output logic [FLAG_W+5:0] csr_rdata,
  output logic              out_valid,
  output logic [2:0]        eff_rm,
  output logic [1:0]        eff_acc,
  output logic [1:0]        eff_fmt,
  output logic              illegal_insn,
  output logic              emu_trap
);
  localparam int RM_LO  = FLAG_W;
  localparam int ACC_LO = FLAG_W + 3;
  localparam logic [2:0] RM_DYN = 3'b111;

  logic [FLAG_W-1:0] flags_q;
  logic [2:0]        frm_q;
  logic [1:0]        acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      frm_q   <= '0;
      acc_q   <= '0;
    end else if (csr_we) begin
      flags_q <= csr_wdata[FLAG_W-1:0];
      frm_q   <= csr_wdata[RM_LO+2:RM_LO];
      acc_q   <= csr_wdata[ACC_LO+1:ACC_LO];
    end
  end

  logic [1:0] acc_serve;
  logic       acc_ok;

  always_comb begin
    acc_serve = acc_q;
    acc_ok    = IMPL_MASK[acc_q];
    if (!acc_ok && ALLOW_UPGRADE) begin
      for (int m = 3; m >= 0; m--) begin
        if (m > int'(acc_q) && IMPL_MASK[m]) begin
          acc_serve = 2'(m);
          acc_ok    = 1'b1;
        end
      end
    end
  end

  wire [2:0] rm_sel = (insn_rm == RM_DYN) ? frm_q : insn_rm;
  wire       rm_bad = (rm_sel == 3'b101) || (rm_sel == 3'b110) || (rm_sel == 3'b111);

  assign illegal_insn = issue_valid && rm_bad;
  assign emu_trap     = issue_valid && !rm_bad && !acc_ok;
  assign out_valid    = issue_valid && !rm_bad && acc_ok;
  assign eff_rm       = out_valid ? rm_sel : 3'b000;
  assign eff_acc      = out_valid ? acc_serve : 2'b00;
  assign eff_fmt      = out_valid ? insn_fmt : 2'b00;
  assign csr_rdata    = {!acc_ok, acc_q, frm_q, flags_q};

  assert_one_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_insn && emu_trap) && !(out_valid && (illegal_insn || emu_trap)));

  assert_served_mode_built_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> IMPL_MASK[eff_acc]);

  assert_never_less_accurate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (eff_acc >= csr_rdata[ACC_LO+1:ACC_LO]));

  assert_pulses_need_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !(out_valid || illegal_insn || emu_trap));

  assert_bad_dynamic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && insn_rm == RM_DYN && csr_rdata[RM_LO+2:RM_LO] >= 3'b101) |-> illegal_insn);

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (csr_rdata[FLAG_W+4:0] == $past(csr_wdata)));

  assert_status_matches_trap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    emu_trap |-> csr_rdata[FLAG_W+5]);
endmodule

// File: tb/sim_fp_round_acc_resolver.sv
module sim_fp_round_acc_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [2:0] insn_rm = '0;
  logic [1:0] insn_fmt = '0;
  logic csr_we = 1'b0;
  logic [9:0] csr_wdata = '0;
  logic [10:0] csr_rdata;
  logic out_valid, illegal_insn, emu_trap;
  logic [2:0] eff_rm;
  logic [1:0] eff_acc, eff_fmt;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fp_round_acc_resolver u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .insn_rm(insn_rm),
    .insn_fmt(insn_fmt), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .out_valid(out_valid), .eff_rm(eff_rm),
    .eff_acc(eff_acc), .eff_fmt(eff_fmt), .illegal_insn(illegal_insn),
    .emu_trap(emu_trap));

  typedef struct packed {
    logic [9:0] csr;
    logic [2:0] rm;
    logic [1:0] fmt;
    logic       v;
    logic [2:0] erm;
    logic [1:0] eacc;
    logic       ill;
    logic       trap;
  } vec_t;

  // implemented modes 00 and 10, upgrade enabled
  localparam vec_t TBL [12] = '{
    '{10'h020, 3'b000, 2'b01, 1'b1, 3'b000, 2'b00, 1'b0, 1'b0},
    '{10'h020, 3'b111, 2'b00, 1'b1, 3'b001, 2'b00, 1'b0, 1'b0},
    '{10'h0A0, 3'b111, 2'b00, 1'b0, 3'b000, 2'b00, 1'b1, 1'b0},
    '{10'h0E0, 3'b111, 2'b10, 1'b0, 3'b000, 2'b00, 1'b1, 1'b0},
    '{10'h0C0, 3'b010, 2'b11, 1'b1, 3'b010, 2'b00, 1'b0, 1'b0},
    '{10'h020, 3'b101, 2'b01, 1'b0, 3'b000, 2'b00, 1'b1, 1'b0},
    '{10'h100, 3'b011, 2'b00, 1'b1, 3'b011, 2'b10, 1'b0, 1'b0},
    '{10'h300, 3'b000, 2'b01, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1},
    '{10'h3E0, 3'b111, 2'b01, 1'b0, 3'b000, 2'b00, 1'b1, 1'b0},
    '{10'h29F, 3'b111, 2'b11, 1'b1, 3'b100, 2'b10, 1'b0, 1'b0},
    '{10'h200, 3'b110, 2'b10, 1'b0, 3'b000, 2'b00, 1'b1, 1'b0},
    '{10'h000, 3'b100, 2'b10, 1'b1, 3'b100, 2'b00, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_csr(input logic [9:0] d);
    @(negedge clk);
    csr_we = 1'b1;
    csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  function automatic logic [10:0] observed();
    return {out_valid, eff_rm, eff_acc, eff_fmt, illegal_insn, emu_trap};
  endfunction

  function automatic string tag_of(input vec_t t);
    if (t.ill && t.csr[9:8] == 2'b11) return "R10";
    if (t.ill) return "R5";
    if (t.trap) return "R9";
    if (t.eacc != t.csr[9:8]) return "R8";
    if (t.rm == 3'b111) return "R4";
    return "R3";
  endfunction

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [10:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    check(csr_rdata == 11'h000, "R1 csr", 32'(csr_rdata), 0);
    check(observed() == 11'h0, "R1 outputs", 32'(observed()), 0);

    for (int i = 0; i < 12; i++) begin
      write_csr(TBL[i].csr);
      insn_rm = TBL[i].rm;
      insn_fmt = TBL[i].fmt;
      issue_valid = 1'b1;
      #2;
      exp = {TBL[i].v, TBL[i].erm, TBL[i].eacc, TBL[i].v ? TBL[i].fmt : 2'b00, TBL[i].ill, TBL[i].trap};
      check(observed() == exp, tag_of(TBL[i]), 32'(observed()), 32'(exp));
      @(negedge clk);
      issue_valid = 1'b0;
    end

    // R6 every format passes through, R7 implemented mode unchanged
    write_csr(10'h200);
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      insn_rm = 3'b001; insn_fmt = 2'(f); issue_valid = 1'b1;
      #2;
      check(out_valid && eff_fmt == 2'(f), "R6 fmt", 32'(eff_fmt), 32'(f));
      check(eff_acc == 2'b10, "R7 acc", 32'(eff_acc), 2);
    end
    @(negedge clk); issue_valid = 1'b0;

    // R10 faulting instruction forwards zeros
    write_csr(10'h3E0);
    @(negedge clk);
    insn_rm = 3'b001; insn_fmt = 2'b11; issue_valid = 1'b1;
    #2;
    check(observed() == 11'b0_000_00_00_0_1, "R10 trap zeros", 32'(observed()), 32'h1);
    @(negedge clk); issue_valid = 1'b0;

    // R11 no issue, no pulse even with bad fields
    insn_rm = 3'b111; insn_fmt = 2'b11;
    #2;
    check(observed() == 11'h0, "R11 idle", 32'(observed()), 0);

    // R2 readback with read-only top bit, R12 status
    write_csr(10'h3FF);
    #2;
    check(csr_rdata == 11'h7FF, "R2 R12 readback", 32'(csr_rdata), 32'h7FF);
    write_csr(10'h155);
    #2;
    check(csr_rdata == 11'h155, "R2 R12 upgrade not emulated", 32'(csr_rdata), 32'h155);
    write_csr(10'h000);
    #2;
    check(csr_rdata[10] == 1'b0, "R12 implemented", 32'(csr_rdata[10]), 0);

    // R2 write and issue in the same cycle use old value
    write_csr(10'h020);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = 10'h060;
    insn_rm = 3'b111; insn_fmt = 2'b00; issue_valid = 1'b1;
    #2;
    check(out_valid && eff_rm == 3'b001, "R2 old value", 32'(eff_rm), 1);
    @(negedge clk);
    csr_we = 1'b0;
    #2;
    check(out_valid && eff_rm == 3'b011, "R2 new value", 32'(eff_rm), 3);
    @(negedge clk); issue_valid = 1'b0;

    // R1 reset clears written state
    write_csr(10'h3FF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(csr_rdata == 11'h000, "R1 re-reset", 32'(csr_rdata), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule